// File: doc/BRIEF.md
# Programmable asynchronous serial transceiver

This block moves bytes between a parallel interface and a single serial wire that carries no clock. The transmit path takes a byte through a valid/ready handshake and sends it as a frame: a low start bit, the data bits least significant first, an optional parity bit and one or two high stop bits. The receive path brings the incoming line through a two-flop synchronizer and watches for a falling edge. It confirms the start bit at its midpoint, samples every following bit at the centre of its interval and presents the rebuilt byte with a one-cycle strobe, together with parity, framing and break flags.

Both paths take their timing from a shared tick generator that fires once every `divisor` clock cycles. A bit lasts 16 ticks, so the bit rate is the clock frequency divided by 16 times the divisor. Word length, parity and stop-bit count are set at run time. The transmitter captures them when it accepts a byte. The receiver uses the live settings, which must stay stable while a frame arrives.

Transmit FSM states: TX_IDLE (line high, ready) → TX_START on accept → TX_DATA after 16 ticks → TX_PARITY (parity enabled) or TX_STOP after the last data bit → TX_STOP → TX_IDLE after the last stop bit, with a second pass through TX_STOP when two stop bits are selected. Receive FSM states: RX_IDLE → RX_START on a synchronized falling edge → RX_IDLE again if the line is high at tick 8 (glitch), otherwise RX_DATA → RX_PARITY (parity enabled) or RX_STOP after the last data bit → RX_IDLE once the first stop bit has been sampled, which is also when the result is issued.

Top module: `async_serial_xcvr`

## Requirements
- R1: After reset `txd` is 1, `tx_ready` is 1 and `rx_valid` is 0. Whenever `tx_ready` is 1, `txd` is 1.
- R2: With a divisor D of 1 or more, every bit on `txd` after the start bit lasts exactly 16·D clock cycles.
- R3: A transmitted frame starts with a low start bit, then sends 5 + `word_len` data bits (`word_len` 0..3 selects 5..8) least significant bit first.
- R4: When `parity_en` is 1, one parity bit follows the last data bit. `parity_mode` 0 makes the count of ones over the data and parity even, 1 makes it odd, 2 sends a constant 1 and 3 sends a constant 0.
- R5: The frame ends with one high stop bit, or two when `two_stop` is 1. `tx_ready` stays 0 from acceptance until the last stop bit has ended and is then 1 again.
- R6: A byte is accepted on a clock edge where `tx_valid` and `tx_ready` are both 1. Changes to `tx_data` after acceptance do not alter the frame being sent.
- R7: For each received frame, `rx_valid` pulses for exactly one cycle. `rx_data` then holds the received bits right-aligned, with the bits above the word length at 0.
- R8: `rx_parity_err` is 1 with `rx_valid` exactly when parity is enabled and the received parity bit differs from the value R4 defines for the received data.
- R9: A low pulse on `rxd` that has ended before the start-bit midpoint (tick 8 after the edge) produces no `rx_valid`, and the next proper frame is received correctly.
- R10: `rx_frame_err` is 1 with `rx_valid` when the first stop bit samples low. When that bit is high, `rx_frame_err` is 0.
- R11: `rx_break` is 1 with `rx_valid` when every sampled bit of the frame, stop bit included, is low. It then comes with `rx_frame_err` = 1 and `rx_data` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| divisor | input | 16 | Clock cycles per oversample tick (0 acts as 1) |
| word_len | input | 2 | Data bits minus 5 |
| parity_en | input | 1 | Append and check a parity bit |
| parity_mode | input | 2 | 0 even, 1 odd, 2 constant 1, 3 constant 0 |
| two_stop | input | 1 | Transmit two stop bits |
| tx_data | input | 8 | Byte to send, right-aligned |
| tx_valid | input | 1 | Byte offered |
| tx_ready | output | 1 | Transmitter idle and accepting |
| txd | output | 1 | Serial output line |
| rxd | input | 1 | Serial input line (asynchronous) |
| rx_data | output | 8 | Received byte, right-aligned |
| rx_valid | output | 1 | One-cycle strobe for a received frame |
| rx_parity_err | output | 1 | Parity mismatch in the last frame |
| rx_frame_err | output | 1 | First stop bit sampled low |
| rx_break | output | 1 | Whole frame sampled low |

## Verification
A transmitter stuck in a wrong state, or with a bit counter off by one, shows on `txd` as a misplaced level at the centre of a bit. A stop bit missing or added shows as `tx_ready` returning at the wrong time, one bit period (16·D cycles) early or late. A receiver fault appears when the frame ends: the strobe is missing or doubled, `rx_data` is shifted by a bit, or a flag is wrong. A receiver that fails to drop a glitch gives a false strobe within about one frame time. Each of these shows within the frame that caused it.

// File: rtl/aserial_pkg.sv
package aserial_pkg;

    typedef enum logic [2:0] {
        TX_IDLE, TX_START, TX_DATA, TX_PARITY, TX_STOP
    } tx_state_t;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_PARITY, RX_STOP
    } rx_state_t;

    localparam logic [1:0] PAR_EVEN  = 2'd0;
    localparam logic [1:0] PAR_ODD   = 2'd1;
    localparam logic [1:0] PAR_MARK  = 2'd2;
    localparam logic [1:0] PAR_SPACE = 2'd3;

    // parity bit for the low (5 + wl) bits of d
    function automatic logic parity_bit(input logic [7:0] d,
                                        input logic [1:0] wl,
                                        input logic [1:0] mode);
        logic [7:0] mask;
        logic       x;
        mask = 8'hFF >> (2'd3 - wl);
        x    = ^(d & mask);
        unique case (mode)
            PAR_EVEN: parity_bit = x;
            PAR_ODD:  parity_bit = ~x;
            PAR_MARK: parity_bit = 1'b1;
            default:  parity_bit = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/aserial_tick.sv
module aserial_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim;

    always_comb begin
        lim  = (divisor == '0) ? ONE : divisor;
        tick = (cnt >= lim - ONE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + ONE;
    end
endmodule

// File: rtl/aserial_tx.sv
module aserial_tx #(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] word_len,
    input  logic       parity_en,
    input  logic [1:0] parity_mode,
    input  logic       two_stop,
    input  logic [7:0] tx_data,
    input  logic       tx_valid,
    output logic       tx_ready,
    output logic       txd
);
    import aserial_pkg::*;
    localparam int CW = $clog2(OSR);
    localparam logic [CW-1:0] LAST_T = CW'(OSR - 1);

    tx_state_t     state;
    logic [7:0]    sh;
    logic [2:0]    bitn;
    logic [2:0]    last_bit;
    logic [CW-1:0] tcnt;
    logic          pbit, pen, two, stopn;

    // state register and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= TX_IDLE;
            sh <= '0; bitn <= '0; tcnt <= '0; last_bit <= '0;
            pbit <= 1'b0; pen <= 1'b0; two <= 1'b0; stopn <= 1'b0;
        end else begin
            unique case (state)
                TX_IDLE: begin
                    if (tx_valid) begin
                        sh       <= tx_data;
                        pbit     <= parity_bit(tx_data, word_len, parity_mode);
                        pen      <= parity_en;
                        two      <= two_stop;
                        last_bit <= {1'b0, word_len} + 3'd4;
                        tcnt     <= '0;
                        state    <= TX_START;
                    end
                end
                default: begin
                    if (tick) begin
                        if (tcnt != LAST_T) begin
                            tcnt <= tcnt + 1'b1;
                        end else begin
                            tcnt <= '0;
                            unique case (state)
                                TX_START: begin
                                    bitn  <= '0;
                                    state <= TX_DATA;
                                end
                                TX_DATA: begin
                                    sh <= sh >> 1;
                                    if (bitn == last_bit) begin
                                        stopn <= 1'b0;
                                        state <= pen ? TX_PARITY : TX_STOP;
                                    end else begin
                                        bitn <= bitn + 3'd1;
                                    end
                                end
                                TX_PARITY: begin
                                    stopn <= 1'b0;
                                    state <= TX_STOP;
                                end
                                default: begin
                                    if (two && !stopn) stopn <= 1'b1;
                                    else               state <= TX_IDLE;
                                end
                            endcase
                        end
                    end
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        tx_ready = 1'b0;
        txd      = 1'b1;
        unique case (state)
            TX_IDLE:   tx_ready = 1'b1;
            TX_START:  txd = 1'b0;
            TX_DATA:   txd = sh[0];
            TX_PARITY: txd = pbit;
            default:   txd = 1'b1;
        endcase
    end
endmodule

// File: rtl/aserial_rx.sv
module aserial_rx #(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] word_len,
    input  logic       parity_en,
    input  logic [1:0] parity_mode,
    input  logic       rxd,
    output logic [7:0] rx_data,
    output logic       rx_valid,
    output logic       rx_parity_err,
    output logic       rx_frame_err,
    output logic       rx_break
);
    import aserial_pkg::*;
    localparam int CW = $clog2(OSR);
    localparam logic [CW-1:0] LAST_T = CW'(OSR - 1);
    localparam logic [CW-1:0] MID_T  = CW'(OSR / 2 - 1);

    rx_state_t     state;
    logic          s1, s2, s3;
    logic [7:0]    sh;
    logic [2:0]    bitn;
    logic [CW-1:0] tcnt;
    logic          pbit, zero;
    logic          fall, full, done;
    logic [7:0]    word;

    always_ff @(posedge clk) begin
        if (!rst_n) {s1, s2, s3} <= 3'b111;
        else        {s1, s2, s3} <= {rxd, s1, s2};
    end

    always_comb begin
        fall = s3 & ~s2;
        full = tick && (tcnt == LAST_T);
        done = full && (state == RX_STOP);
        word = sh >> (2'd3 - word_len);
    end

    // state register and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RX_IDLE;
            sh <= '0; bitn <= '0; tcnt <= '0; pbit <= 1'b0; zero <= 1'b0;
        end else begin
            if (tick && state != RX_IDLE) tcnt <= full ? '0 : tcnt + 1'b1;
            unique case (state)
                RX_IDLE: begin
                    if (fall) begin
                        tcnt  <= '0;
                        zero  <= 1'b1;
                        state <= RX_START;
                    end
                end
                RX_START: begin
                    if (tick && tcnt == MID_T) begin
                        tcnt <= '0;
                        bitn <= '0;
                        state <= s2 ? RX_IDLE : RX_DATA;
                    end
                end
                RX_DATA: begin
                    if (full) begin
                        sh   <= {s2, sh[7:1]};
                        zero <= zero & ~s2;
                        if (bitn == {1'b0, word_len} + 3'd4)
                            state <= parity_en ? RX_PARITY : RX_STOP;
                        else
                            bitn <= bitn + 3'd1;
                    end
                end
                RX_PARITY: begin
                    if (full) begin
                        pbit  <= s2;
                        zero  <= zero & ~s2;
                        state <= RX_STOP;
                    end
                end
                default: begin
                    if (full) state <= RX_IDLE;
                end
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_valid <= 1'b0; rx_data <= '0;
            rx_parity_err <= 1'b0; rx_frame_err <= 1'b0; rx_break <= 1'b0;
        end else begin
            rx_valid <= done;
            if (done) begin
                rx_data       <= word;
                rx_parity_err <= parity_en &&
                                 (pbit != parity_bit(word, word_len, parity_mode));
                rx_frame_err  <= ~s2;
                rx_break      <= zero & ~s2;
            end
        end
    end
endmodule

// File: rtl/async_serial_xcvr.sv
module async_serial_xcvr #(
    parameter int DIV_W = 16,
    parameter int OSR   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    input  logic [1:0]       word_len,
    input  logic             parity_en,
    input  logic [1:0]       parity_mode,
    input  logic             two_stop,
    input  logic [7:0]       tx_data,
    input  logic             tx_valid,
    output logic             tx_ready,
    output logic             txd,
    input  logic             rxd,
    output logic [7:0]       rx_data,
    output logic             rx_valid,
    output logic             rx_parity_err,
    output logic             rx_frame_err,
    output logic             rx_break
);
    logic tick;

    aserial_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .divisor(divisor), .tick(tick)
    );

    aserial_tx #(.OSR(OSR)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .word_len(word_len), .parity_en(parity_en),
        .parity_mode(parity_mode), .two_stop(two_stop),
        .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .txd(txd)
    );

    aserial_rx #(.OSR(OSR)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .word_len(word_len), .parity_en(parity_en),
        .parity_mode(parity_mode), .rxd(rxd),
        .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_parity_err(rx_parity_err), .rx_frame_err(rx_frame_err),
        .rx_break(rx_break)
    );
endmodule

// File: rtl/aserial_xcvr_chk.sv
module aserial_xcvr_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic       txd,
    input logic [7:0] rx_data,
    input logic       rx_valid,
    input logic       rx_frame_err,
    input logic       rx_break
);
    a_r1_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> txd);

    a_r3_start_bit_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_ready) |-> !txd);

    a_r6_accept_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_ready);

    a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    a_r11_break_is_frame_err: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_break) |-> (rx_frame_err && rx_data == 8'h00));
endmodule

bind async_serial_xcvr aserial_xcvr_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .txd(txd), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_frame_err(rx_frame_err), .rx_break(rx_break)
);

// File: tb/async_serial_xcvr_tb.sv
`timescale 1ns/1ps
module async_serial_xcvr_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] divisor = 16'd2;
    logic [1:0]  word_len = 2'd3;
    logic        parity_en = 1'b0;
    logic [1:0]  parity_mode = 2'd0;
    logic        two_stop = 1'b0;
    logic [7:0]  tx_data = 8'h00;
    logic        tx_valid = 1'b0;
    logic        tx_ready, txd;
    logic        rxd = 1'b1;
    logic [7:0]  rx_data;
    logic        rx_valid, rx_parity_err, rx_frame_err, rx_break;

    int nchk = 0;
    int nerr = 0;
    bit reported = 0;

    // captured receive result
    bit       got = 0;
    int       got_n = 0;
    logic [7:0] g_data;
    logic     g_perr, g_ferr, g_brk;

    always #2.5 clk = ~clk;

    async_serial_xcvr u_dut (
        .clk(clk), .rst_n(rst_n), .divisor(divisor), .word_len(word_len),
        .parity_en(parity_en), .parity_mode(parity_mode), .two_stop(two_stop),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd),
        .rxd(rxd), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_parity_err(rx_parity_err), .rx_frame_err(rx_frame_err),
        .rx_break(rx_break)
    );

    always @(negedge clk) begin
        if (rx_valid) begin
            got = 1; got_n++;
            g_data = rx_data; g_perr = rx_parity_err;
            g_ferr = rx_frame_err; g_brk = rx_break;
        end
    end

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        end
    endtask

    function automatic logic exp_par(input logic [7:0] d, input int n, input logic [1:0] m);
        int ones = 0;
        for (int i = 0; i < n; i++) ones += d[i];
        case (m)
            2'd0: return logic'(ones % 2);
            2'd1: return logic'((ones + 1) % 2);
            2'd2: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    // send one byte and decode txd at bit centres
    task automatic tx_frame(input logic [7:0] d, input logic [1:0] wl, input bit pe,
                            input logic [1:0] pm, input bit ts, input int dv);
        int n, nb, pos;
        logic [7:0] dm;
        @(negedge clk);
        divisor = 16'(dv); word_len = wl; parity_en = pe; parity_mode = pm; two_stop = ts;
        tx_data = d; tx_valid = 1'b1;
        chk(tx_ready === 1'b1, "R6 ready before accept", tx_ready, 1);
        @(posedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
        tx_data = 8'($urandom);            // R6: must not disturb the frame
        n  = 5 + wl;
        nb = 1 + n + (pe ? 1 : 0) + (ts ? 2 : 1);
        dm = d & (8'hFF >> (8 - n));
        pos = 0;
        for (int k = 0; k < nb; k++) begin
            repeat ((k * 16 + 8) * dv - pos) @(negedge clk);
            pos = (k * 16 + 8) * dv;
            if (k == 0)
                chk(txd === 1'b0, "R3 start bit", txd, 0);
            else if (k <= n)
                chk(txd === dm[k-1], $sformatf("R3 data bit %0d (R6 latched)", k-1), txd, dm[k-1]);
            else if (pe && k == n + 1)
                chk(txd === exp_par(dm, n, pm), "R4 parity bit", txd, exp_par(dm, n, pm));
            else
                chk(txd === 1'b1, "R5 stop bit", txd, 1);
        end
        chk(tx_ready === 1'b0, "R5 busy during last stop", tx_ready, 0);
        repeat (nb * 16 * dv + dv + 2 - pos) @(negedge clk);
        chk(tx_ready === 1'b1, "R5 ready after frame", tx_ready, 1);
        chk(txd === 1'b1, "R1 idle line", txd, 1);
    endtask

    // measure the width of data bit 0 of 0x55
    task automatic bit_period(input int dv);
        int t;
        @(negedge clk);
        divisor = 16'(dv); word_len = 2'd3; parity_en = 1'b0; two_stop = 1'b0;
        tx_data = 8'h55; tx_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
        while (txd !== 1'b1) @(negedge clk);
        t = 0;
        while (txd === 1'b1) begin @(negedge clk); t++; end
        chk(t == 16 * dv, $sformatf("R2 bit period div=%0d", dv), t, 16 * dv);
        while (tx_ready !== 1'b1) @(negedge clk);
    endtask

    // drive a frame on rxd, bit 0 first
    task automatic rx_drive(input logic [15:0] bits, input int nb, input int dv);
        for (int i = 0; i < nb; i++) begin
            rxd = bits[i];
            repeat (16 * dv) @(negedge clk);
        end
        rxd = 1'b1;
        repeat (16 * dv) @(negedge clk);
    endtask

    task automatic rx_frame(input logic [7:0] d, input logic [1:0] wl, input bit pe,
                            input logic [1:0] pm, input bit flip, input int dv);
        logic [15:0] bits;
        int n, nb;
        logic [7:0] dm;
        logic p;
        n  = 5 + wl;
        dm = d & (8'hFF >> (8 - n));
        p  = exp_par(dm, n, pm) ^ flip;
        bits = '1;
        bits[0] = 1'b0;
        for (int i = 0; i < n; i++) bits[1 + i] = dm[i];
        nb = 1 + n;
        if (pe) begin bits[nb] = p; nb++; end
        bits[nb] = 1'b1; nb++;
        @(negedge clk);
        divisor = 16'(dv); word_len = wl; parity_en = pe; parity_mode = pm;
        got = 0; got_n = 0;
        rx_drive(bits, nb, dv);
        chk(got && got_n == 1, "R7 one strobe per frame", got_n, 1);
        chk(g_data === dm, "R7 received data", g_data, dm);
        chk(g_perr === (pe && flip), "R8 parity flag", g_perr, pe && flip);
        chk(g_ferr === 1'b0, "R10 no framing error", g_ferr, 0);
        chk(g_brk === 1'b0, "R11 no break", g_brk, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog expired actual=hung expected=done");
        report();
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(txd === 1'b1, "R1 reset txd", txd, 1);
        chk(tx_ready === 1'b1, "R1 reset tx_ready", tx_ready, 1);
        chk(rx_valid === 1'b0, "R1 reset rx_valid", rx_valid, 0);

        bit_period(2);
        bit_period(5);

        // directed transmit corners
        tx_frame(8'hFF, 2'd0, 1'b1, 2'd0, 1'b1, 1);
        tx_frame(8'h01, 2'd3, 1'b1, 2'd1, 1'b0, 2);
        tx_frame(8'h00, 2'd2, 1'b1, 2'd2, 1'b0, 1);
        tx_frame(8'hFF, 2'd1, 1'b1, 2'd3, 1'b1, 3);
        for (int i = 0; i < 16; i++)
            tx_frame(8'($urandom), 2'($urandom), 1'($urandom), 2'($urandom),
                     1'($urandom), 1 + int'($urandom % 3));

        // receive: directed and random
        rx_frame(8'hA5, 2'd3, 1'b0, 2'd0, 1'b0, 2);
        rx_frame(8'h1F, 2'd0, 1'b1, 2'd1, 1'b1, 1);
        for (int i = 0; i < 16; i++)
            rx_frame(8'($urandom), 2'($urandom), 1'($urandom), 2'($urandom),
                     1'($urandom), 1 + int'($urandom % 3));

        // R9 glitch rejection
        @(negedge clk);
        divisor = 16'd3; word_len = 2'd3; parity_en = 1'b0;
        got = 0; got_n = 0;
        rxd = 1'b0;
        repeat (6) @(negedge clk);
        rxd = 1'b1;
        repeat (12 * 16 * 3) @(negedge clk);
        chk(got_n == 0, "R9 glitch gives no strobe", got_n, 0);
        rx_frame(8'h3C, 2'd3, 1'b0, 2'd0, 1'b0, 3);

        // R10 framing error: stop bit low, data nonzero
        @(negedge clk);
        divisor = 16'd2; word_len = 2'd3; parity_en = 1'b0;
        got = 0;
        rx_drive({6'h3F, 1'b0, 8'hA5, 1'b0}, 10, 2);
        chk(got && g_ferr === 1'b1, "R10 framing error flag", g_ferr, 1);
        chk(g_brk === 1'b0, "R11 no break on framing error", g_brk, 0);
        chk(g_data === 8'hA5, "R10 data kept", g_data, 8'hA5);

        // R11 break: whole frame low, then back high
        got = 0;
        rx_drive(16'h0000, 12, 2);
        chk(got && g_brk === 1'b1, "R11 break flag", g_brk, 1);
        chk(g_ferr === 1'b1, "R11 break with framing error", g_ferr, 1);
        chk(g_data === 8'h00, "R11 break data", g_data, 0);
        rx_frame(8'h96, 2'd3, 1'b0, 2'd0, 1'b0, 2);

        report();
        $finish;
    end
endmodule